// File: doc/BRIEF.md
# Flash Embedded Operation Status Reporter

This block sits beside the command decoder of a flash device model and in front of its read port. A one-cycle start pulse launches a byte program, a sector erase or a whole-array erase. The block then counts that operation's duration in clock cycles and raises a busy flag for exactly that long. When the operation ends, busy drops and a one-cycle done pulse appears. A whole-array erase walks a sector index across every sector. An unlocked sector costs a full per-sector interval, and a locked boot sector is passed over in one cycle.

The read path has two stages. Read requests come in on a valid/ready channel, and each accepted request produces one response byte on a valid/ready channel one cycle later. Back-pressure works as follows. `rd_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that is not taken stays valid and unchanged until `rsp_ready` is high. The response byte comes from one of three sources, in this order of precedence. While busy, it is a status byte. When idle with the identification mode selected, it is a fixed identity byte. Otherwise it is the array byte presented on `arr_data`. The status byte has two live bits: bit 7 is the polling bit and bit 6 flips on every accepted busy read.

Top module: `flash_status_unit`

## Requirements
- R1: An `op_start` accepted while idle with `op_kind`=0 (byte program) raises `busy` on the next cycle and holds it for exactly PROG_CYCLES cycles.
- R2: A sector erase (`op_kind`=1) keeps `busy` high for exactly SECT_CYCLES cycles.
- R3: A whole-array erase (`op_kind`=2) keeps `busy` high for the sum of a per-sector cost over all SECTORS sectors. The cost is CHIP_SECT_CYCLES for an unlocked sector and 1 for a boot sector that is locked. Lock state is sampled at start, and the boot sectors are the top BOOT_SECTORS indices when TOP_BOOT=1.
- R4: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after an operation.
- R5: These starts are ignored, so `busy` stays low: `op_kind`=3; a sector erase whose `op_sector` is a boot sector while `boot_lock`=1. A start while busy is also ignored, leaving the running operation's duration and status unchanged.
- R6: A read accepted while busy returns {P, T, 6'b0}, and this takes precedence over identification mode. P is the inverse of `op_wdata7` latched at a program start, and 0 for any erase.
- R7: Bit 6 of the status byte inverts on every accepted busy read, so two consecutive busy reads always differ in bit 6.
- R8: A read accepted while idle with `autosel`=0 returns `arr_data` as sampled in the accept cycle.
- R9: A read accepted while idle with `autosel`=1 returns an identity byte selected by `rd_addr_lo` (bit 0 = A0, bit 1 = A1): 00 gives 40h; 01 gives 01h when TOP_BOOT=1 and A1h otherwise; 10 gives 01h if `boot_lock` is 1 and 00h if it is 0; 11 gives 00h.
- R10: Each accepted request yields `rsp_valid` on the next cycle. While `rsp_valid`=1 and `rsp_ready`=0, `rd_ready` is low and `rsp_data` holds.
- R11: After reset, `busy`, `done` and `rsp_valid` are 0 and `rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle operation launch |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 reserved |
| op_sector | input | SEC_W | Target sector of a sector erase |
| op_wdata7 | input | 1 | Bit 7 of the byte being programmed |
| boot_lock | input | 1 | Boot sectors are protected |
| autosel | input | 1 | Identification read mode |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_addr_lo | input | 2 | Low read address bits (A1, A0) |
| arr_data | input | 8 | Array byte for the current read address |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Response byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench builds the block with these parameters:
- eight sectors, two of them top boot sectors;
- PROG_CYCLES=12, SECT_CYCLES=20 and CHIP_SECT_CYCLES=3.

With these values, every duration fits in a few dozen cycles. Both whole-array erase totals can be reached: 24 cycles unlocked and 20 cycles locked. The settings also leave room for several status reads inside one program or erase. A behavioural model predicts busy, done and every response byte on each clock. Directed phases cover the boot-sector refusal, the reserved kind, precedence of status over identity bytes, and a held response under back-pressure.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_e;

  localparam logic [7:0] MFR_CODE   = 8'h40;
  localparam logic [7:0] DEV_TOP    = 8'h01;
  localparam logic [7:0] DEV_BOTTOM = 8'hA1;
  localparam logic [7:0] LOCK_YES   = 8'h01;
  localparam logic [7:0] LOCK_NO    = 8'h00;
  localparam logic [7:0] ID_SPARE   = 8'h00;
endpackage

// File: rtl/fsu_timer.sv
module fsu_timer
  import fsu_pkg::*;
#(
  parameter int SECTORS          = 256,
  parameter int BOOT_SECTORS     = 16,
  parameter bit TOP_BOOT         = 1'b1,
  parameter int PROG_CYCLES      = 5000,
  parameter int SECT_CYCLES      = 2500000,
  parameter int CHIP_SECT_CYCLES = 488281,
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_kind_e         kind,
  input  logic [SEC_W-1:0] sector,
  input  logic             lock,
  output logic             accept,
  output logic             busy,
  output logic             done
);
  localparam int MAX_AB = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAXC   = (MAX_AB > CHIP_SECT_CYCLES) ? MAX_AB : CHIP_SECT_CYCLES;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS - 1);
  localparam logic [SEC_W:0]   TOP_LO   = (SEC_W+1)'(SECTORS - BOOT_SECTORS);
  localparam logic [SEC_W:0]   BOT_HI   = (SEC_W+1)'(BOOT_SECTORS);

  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;
  logic             chip_q, lock_q, busy_q, done_q;

  function automatic logic is_locked(input logic [SEC_W-1:0] s, input logic l);
    logic in_boot;
    in_boot = TOP_BOOT ? ({1'b0, s} >= TOP_LO) : ({1'b0, s} < BOT_HI);
    return l && in_boot;
  endfunction

  function automatic logic [CNT_W-1:0] sec_load(input logic [SEC_W-1:0] s, input logic l);
    return is_locked(s, l) ? '0 : CNT_W'(CHIP_SECT_CYCLES - 1);
  endfunction

  assign accept = start && !busy_q && (kind != OP_RSVD) &&
                  !((kind == OP_SECT) && is_locked(sector, lock));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sec_q  <= '0;
      chip_q <= 1'b0;
      lock_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          if (chip_q && (sec_q != LAST_SEC)) begin
            sec_q <= sec_q + 1'b1;
            cnt_q <= sec_load(sec_q + 1'b1, lock_q);
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (accept) begin
        busy_q <= 1'b1;
        lock_q <= lock;
        chip_q <= (kind == OP_CHIP);
        sec_q  <= '0;
        case (kind)
          OP_PROG: cnt_q <= CNT_W'(PROG_CYCLES - 1);
          OP_SECT: cnt_q <= CNT_W'(SECT_CYCLES - 1);
          default: cnt_q <= sec_load('0, lock);
        endcase
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/fsu_id_rom.sv
module fsu_id_rom
  import fsu_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [1:0] sel,
  input  logic       lock,
  output logic [7:0] id_byte
);
  always_comb begin
    case (sel)
      2'b00:   id_byte = MFR_CODE;
      2'b01:   id_byte = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;
      2'b10:   id_byte = lock ? LOCK_YES : LOCK_NO;
      default: id_byte = ID_SPARE;
    endcase
  end
endmodule

// File: rtl/fsu_read_port.sv
module fsu_read_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_valid,
  output logic       rd_ready,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       busy,
  input  logic       poll_bit,
  input  logic       autosel,
  input  logic [7:0] id_byte,
  input  logic [7:0] arr_data
);
  logic       vld_q, tgl_q;
  logic [7:0] dat_q, pick;
  logic       take;

  assign rd_ready = !vld_q || rsp_ready;
  assign take     = rd_valid && rd_ready;

  always_comb begin
    if (busy)         pick = {poll_bit, tgl_q, 6'b0};
    else if (autosel) pick = id_byte;
    else              pick = arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tgl_q <= 1'b0;
      dat_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      dat_q <= pick;
      if (busy) tgl_q <= ~tgl_q;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter int SECTORS          = 256,
  parameter int BOOT_SECTORS     = 16,
  parameter bit TOP_BOOT         = 1'b1,
  parameter int PROG_CYCLES      = 5000,
  parameter int SECT_CYCLES      = 2500000,
  parameter int CHIP_SECT_CYCLES = 488281,
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [1:0]       op_kind,
  input  logic [SEC_W-1:0] op_sector,
  input  logic             op_wdata7,
  input  logic             boot_lock,
  input  logic             autosel,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [1:0]       rd_addr_lo,
  input  logic [7:0]       arr_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             busy,
  output logic             done
);
  op_kind_e   kind_e;
  logic       accept;
  logic       poll_q;
  logic [7:0] id_byte;

  assign kind_e = op_kind_e'(op_kind);

  fsu_timer #(
    .SECTORS(SECTORS), .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT),
    .PROG_CYCLES(PROG_CYCLES), .SECT_CYCLES(SECT_CYCLES),
    .CHIP_SECT_CYCLES(CHIP_SECT_CYCLES)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .start(op_start), .kind(kind_e),
    .sector(op_sector), .lock(boot_lock), .accept(accept),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      poll_q <= 1'b0;
    else if (accept) poll_q <= (kind_e == OP_PROG) ? ~op_wdata7 : 1'b0;
  end

  fsu_id_rom #(.TOP_BOOT(TOP_BOOT)) id_i (
    .sel(rd_addr_lo), .lock(boot_lock), .id_byte(id_byte)
  );

  fsu_read_port rp_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .poll_bit(poll_q), .autosel(autosel),
    .id_byte(id_byte), .arr_data(arr_data)
  );
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data
);
  AST_PROG_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy && op_kind == 2'd0) |=> busy); // R1
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
endmodule

bind flash_status_unit fsu_checker chk_i (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
  .busy(busy), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/flash_status_unit_tb_top.sv
`timescale 1ns/1ps
module flash_status_unit_tb_top;
  localparam int NS = 8, NB = 2, PC = 12, SC = 20, CC = 3;
  localparam int SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 0, op_wdata7 = 0, boot_lock = 0, autosel = 0;
  logic [1:0] op_kind = 0, rd_addr_lo = 0;
  logic [SW-1:0] op_sector = 0;
  logic rd_valid = 0, rsp_ready = 1;
  logic [7:0] arr_data = 0;
  logic rd_ready, rsp_valid, busy, done;
  logic [7:0] rsp_data;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R11";

  always #2 clk = ~clk;

  flash_status_unit #(.SECTORS(NS), .BOOT_SECTORS(NB), .TOP_BOOT(1'b1),
    .PROG_CYCLES(PC), .SECT_CYCLES(SC), .CHIP_SECT_CYCLES(CC)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_sector(op_sector), .op_wdata7(op_wdata7), .boot_lock(boot_lock),
    .autosel(autosel), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr_lo(rd_addr_lo), .arr_data(arr_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .busy(busy), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_rv, m_tgl, m_p7;
  bit [7:0] m_rd;
  int m_rem;

  function automatic int dur(input int k, input bit l);
    if (k == 0) return PC;
    if (k == 1) return SC;
    return l ? (NS - NB) * CC + NB : NS * CC;
  endfunction

  function automatic bit refused(input int k, input int s, input bit l);
    return (k == 3) || (k == 1 && l && s >= NS - NB);
  endfunction

  function automatic bit [7:0] idb(input int a, input bit l);
    case (a)
      0: return 8'h40;
      1: return 8'h01;
      2: return l ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rv = 0; m_tgl = 0; m_p7 = 0; m_rd = 0; m_rem = 0;
    end else begin
      if (rd_valid && (!m_rv || rsp_ready)) begin
        m_rv = 1;
        if (m_busy) begin m_rd = {m_p7, m_tgl, 6'b0}; m_tgl = ~m_tgl; end
        else if (autosel) m_rd = idb(int'(rd_addr_lo), boot_lock);
        else m_rd = arr_data;
      end else if (rsp_ready) m_rv = 0;
      m_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
      end else if (op_start && !refused(int'(op_kind), int'(op_sector), boot_lock)) begin
        m_busy = 1;
        m_rem = dur(int'(op_kind), boot_lock);
        m_p7 = (op_kind == 2'd0) ? ~op_wdata7 : 1'b0;
      end
    end
    if (cyc > 20000) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int run = 0, last_len = 0;
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk({tag, " busy"}, int'(busy), int'(m_busy));
      chk({tag, " done R4"}, int'(done), int'(m_done));
      chk({tag, " rsp_valid R10"}, int'(rsp_valid), int'(m_rv));
      if (m_rv) chk({tag, " rsp_data"}, int'(rsp_data), int'(m_rd));
    end
    if (busy) run++;
    if (done) begin last_len = run; run = 0; end
  end

  task automatic do_read(input logic [1:0] lo, input logic [7:0] arr, output logic [7:0] got);
    @(negedge clk); rd_valid = 1; rd_addr_lo = lo; arr_data = arr;
    @(negedge clk); rd_valid = 0; got = rsp_data;
    chk({tag, " read response R10"}, int'(rsp_valid), 1);
  endtask

  task automatic start_op(input int k, input int s, input bit d7);
    @(negedge clk); op_start = 1; op_kind = 2'(k); op_sector = SW'(s); op_wdata7 = d7;
    @(negedge clk); op_start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] a, b;
    repeat (3) @(negedge clk);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 rsp_valid", int'(rsp_valid), 0);
    chk("R11 rd_ready", int'(rd_ready), 1);
    rst_n = 1;

    tag = "R8";
    do_read(2'd1, 8'h3C, a); chk("R8 idle pass", int'(a), 8'h3C);

    tag = "R9"; autosel = 1;
    do_read(2'd0, 8'hEE, a); chk("R9 maker", int'(a), 8'h40);
    do_read(2'd1, 8'hEE, a); chk("R9 device top", int'(a), 8'h01);
    boot_lock = 0; do_read(2'd2, 8'hEE, a); chk("R9 unlocked", int'(a), 8'h00);
    boot_lock = 1; do_read(2'd2, 8'hEE, a); chk("R9 locked", int'(a), 8'h01);
    do_read(2'd3, 8'hEE, a); chk("R9 spare", int'(a), 8'h00);
    autosel = 0; boot_lock = 0;

    tag = "R1";
    start_op(0, 0, 1'b0);
    do_read(2'd0, 8'h11, a); do_read(2'd0, 8'h11, b);
    chk("R6 program poll bit", int'(a[7]), 1);
    chk("R6 low bits", int'(a[5:0]), 0);
    chk("R7 toggle differs", int'(a[6] ^ b[6]), 1);
    start_op(2, 0, 1'b1);                       // R5 start while busy
    do_read(2'd0, 8'h11, a); chk("R5 poll unchanged", int'(a[7]), 1);
    wait_done(); chk("R1 R5 program length", last_len, PC);
    do_read(2'd0, 8'hA7, a); chk("R8 true data after", int'(a), 8'hA7);

    tag = "R2"; boot_lock = 1;
    start_op(1, 0, 1'b1);
    autosel = 1; do_read(2'd0, 8'hFF, a); autosel = 0;
    chk("R6 erase poll bit over id", int'(a[7]), 0);
    chk("R6 erase low bits", int'(a[5:0]), 0);
    wait_done(); chk("R2 sector length", last_len, SC);

    tag = "R5";
    start_op(1, 7, 1'b0); @(negedge clk); chk("R5 locked sector refused", int'(busy), 0);
    start_op(3, 0, 1'b0); @(negedge clk); chk("R5 reserved kind", int'(busy), 0);

    tag = "R3";
    boot_lock = 0; start_op(2, 0, 1'b0); wait_done();
    chk("R3 chip unlocked", last_len, NS * CC);
    boot_lock = 1; start_op(2, 0, 1'b0); wait_done();
    chk("R3 chip locked", last_len, (NS - NB) * CC + NB);
    boot_lock = 0;

    tag = "R10";
    @(negedge clk); rsp_ready = 0; rd_valid = 1; rd_addr_lo = 0; arr_data = 8'h5A;
    @(negedge clk); arr_data = 8'hC3;
    chk("R10 valid", int'(rsp_valid), 1);
    chk("R10 ready low", int'(rd_ready), 0);
    @(negedge clk); @(negedge clk);
    chk("R10 held data", int'(rsp_data), 8'h5A);
    rsp_ready = 1;
    @(negedge clk); rd_valid = 0;
    chk("R10 next accepted", int'(rsp_data), 8'hC3);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule